// File: doc/BRIEF.md
# Fixed-Interval Hardware Watchdog

This block is a watchdog that firmware cannot switch off. It runs from the slow crystal-oscillator clock. A counter counts oscillator cycles from the last refresh. If firmware lets it reach the terminal count, the block asks for a full chip reset. It then keeps the processor held for a fixed number of oscillator cycles, and finally releases it to fetch from a fixed start address.

A sticky overflow flag records that the last restart came from the watchdog. Firmware reads it after wake-up to tell a watchdog restart from a power-up. The flag stays set through the watchdog's own reset. Only a firmware clear strobe or the external reset pin removes it.

There are two ways to take the watchdog out of service, and both are levels at dedicated inputs: a debug-disable input and an emulator-enable input. All asynchronous inputs enter the oscillator domain through a synchronizer chain of `SYNC_STAGES` flops. The defaults are `TERM_COUNT` = 49152 (1.5 s at 32768 Hz), `LAUNCH_CYCLES` = 4100 (about 125 ms) and `START_ADDR` = 0.

Top module: `hwdog_core`

## Requirements
- R1: While `rst_pin_i` is high and right after it falls, `sys_rst_o` = 0, `cpu_run_o` = 1, `ovf_flag_o` = 0 and `start_addr_o` = `START_ADDR`.
- R2: With no refresh, `sys_rst_o` rises `TERM_COUNT` oscillator cycles after the last cycle in which the counter was cleared.
- R3: A rising edge on `kick_i` restarts the count from zero. Refresh edges spaced at most `TERM_COUNT` cycles apart never cause an overflow; a spacing of `TERM_COUNT`+1 does.
- R4: After an overflow, `sys_rst_o` stays high and `cpu_run_o` stays low for exactly `LAUNCH_CYCLES` cycles. Then `cpu_run_o` returns to 1 with `start_addr_o` = `START_ADDR`.
- R5: `ovf_flag_o` goes to 1 in the cycle the overflow is taken. It stays 1 through the hold window and after the processor is released.
- R6: A rising edge on `flag_clr_i` clears `ovf_flag_o`.
- R7: `rst_pin_i` high clears `ovf_flag_o` at once (asynchronous).
- R8: While `wake_i` is 0, the counter is held at zero and no overflow occurs.
- R9: While `dbg_off_i` or `emu_en_i` is 1, the counter is held at zero and no overflow occurs.
- R10: Refresh edges during the hold window are ignored. The hold length is unchanged, and the next overflow still falls `TERM_COUNT` cycles after the release.
- R11: Every input except the clock and `rst_pin_i` passes `SYNC_STAGES` flops. A refresh edge is applied `SYNC_STAGES`+1 edges after it is sampled, so `sys_rst_o` is seen `SYNC_STAGES`+`TERM_COUNT`+1 edges later. A release of `wake_i`, `dbg_off_i` or `emu_en_i` gives an overflow after `SYNC_STAGES`+`TERM_COUNT` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc_i | input | 1 | Crystal-oscillator clock |
| rst_pin_i | input | 1 | External reset pin, active high, asynchronous |
| kick_i | input | 1 | Refresh request; a rising edge restarts the count |
| flag_clr_i | input | 1 | Firmware clear of the overflow flag; acts on its rising edge |
| wake_i | input | 1 | Wake level; while 0 the counter is held cleared |
| dbg_off_i | input | 1 | Debug-disable level |
| emu_en_i | input | 1 | Emulator-enable level; disables the watchdog |
| sys_rst_o | output | 1 | Chip reset request, high through the hold window |
| cpu_run_o | output | 1 | Processor release; low while held |
| start_addr_o | output | ADDR_W | Address the processor starts from after release |
| ovf_flag_o | output | 1 | Sticky overflow status flag |

## Verification
The checker looks at every cycle for four things:
- each reset window lasts exactly the launch length;
- each rise of the reset request finds the flag set and no flag rise happens without one;
- the processor is released when the window ends;
- no overflow appears while the emulator input has been high for longer than the synchronizer depth.

Only the bench can show the absolute timing: the exact distance from a refresh, wake or disable release to the overflow. It also covers the refresh-spacing boundary, which it sweeps over every spacing. The effect of the flag clear strobe and of the reset pin, and the ignored refresh during the hold window, are likewise shown only by the bench.

// File: rtl/hwdog_pkg.sv
package hwdog_pkg;

   // Positions of the asynchronous inputs inside the synchronizer vector.
   localparam int unsigned IN_KICK  = 0;
   localparam int unsigned IN_CLR   = 1;
   localparam int unsigned IN_WAKE  = 2;
   localparam int unsigned IN_DBG   = 3;
   localparam int unsigned IN_EMU   = 4;
   localparam int unsigned IN_COUNT = 5;

   typedef enum logic {
      PH_RUN  = 1'b0,
      PH_HOLD = 1'b1
   } wd_phase_e;

   typedef struct packed {
      logic kick_evt;
      logic clr_evt;
      logic awake;
      logic disabled;
   } wd_ctrl_t;

endpackage

// File: rtl/hwdog_sync.sv
module hwdog_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hwdog_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hwdog_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;

      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            chain_q <= '0;
         end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i[b]};
         end
      end

      assign sync_o[b] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/hwdog_edge.sv
module hwdog_edge #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] level_i,
   output logic [WIDTH-1:0] rise_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("hwdog_edge: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         prev_q <= '0;
      end else begin
         prev_q <= level_i;
      end
   end

   assign rise_o = level_i & ~prev_q;

endmodule

// File: rtl/hwdog_interval.sv
module hwdog_interval #(
   parameter int unsigned TERM_COUNT = 49152
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clear_i,
   output logic ovf_o
);

   localparam int unsigned CNT_W = (TERM_COUNT < 2) ? 1 : $clog2(TERM_COUNT);
   localparam bit          POW2  = (TERM_COUNT >= 2) && ((TERM_COUNT & (TERM_COUNT - 1)) == 0);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM_COUNT - 1);

   if (TERM_COUNT < 2) begin : g_bad_term
      $error("hwdog_interval: TERM_COUNT must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   // Terminal detection: all-ones reduction when the limit is a power of two,
   // full compare otherwise.
   if (POW2) begin : g_pow2
      assign at_last = &cnt_q;
   end else begin : g_cmp
      assign at_last = (cnt_q == LAST);
   end

   assign ovf_o = at_last & ~clear_i;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q <= '0;
      end else if (clear_i || at_last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/hwdog_launch.sv
module hwdog_launch
   import hwdog_pkg::*;
#(
   parameter int unsigned LAUNCH_CYCLES = 4100
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic ovf_i,
   input  logic clr_evt_i,
   output logic hold_o,
   output logic run_o,
   output logic flag_o
);

   localparam int unsigned HC_W = $clog2(LAUNCH_CYCLES + 1);
   localparam logic [HC_W-1:0] HC_LOAD = HC_W'(LAUNCH_CYCLES - 1);

   if (LAUNCH_CYCLES < 1) begin : g_bad_launch
      $error("hwdog_launch: LAUNCH_CYCLES must be at least 1");
   end

   wd_phase_e       phase_q;
   logic [HC_W-1:0] hold_cnt_q;
   logic            run_q;
   logic            flag_q;
   logic            take_ovf;
   logic            hold_done;

   assign take_ovf  = (phase_q == PH_RUN) && ovf_i;
   assign hold_done = (phase_q == PH_HOLD) && (hold_cnt_q == '0);

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         phase_q    <= PH_RUN;
         hold_cnt_q <= '0;
      end else if (take_ovf) begin
         phase_q    <= PH_HOLD;
         hold_cnt_q <= HC_LOAD;
      end else if (hold_done) begin
         phase_q    <= PH_RUN;
      end else if (phase_q == PH_HOLD) begin
         hold_cnt_q <= hold_cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         run_q <= 1'b1;
      end else if (take_ovf) begin
         run_q <= 1'b0;
      end else if (hold_done) begin
         run_q <= 1'b1;
      end
   end

   // Sticky flag: the overflow sets it and wins over a simultaneous clear;
   // only the clear event or the reset pin takes it down.
   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         flag_q <= 1'b0;
      end else if (take_ovf) begin
         flag_q <= 1'b1;
      end else if (clr_evt_i) begin
         flag_q <= 1'b0;
      end
   end

   assign hold_o = (phase_q == PH_HOLD);
   assign run_o  = run_q;
   assign flag_o = flag_q;

endmodule

// File: rtl/hwdog_core.sv
module hwdog_core
   import hwdog_pkg::*;
#(
   parameter int unsigned TERM_COUNT    = 49152,
   parameter int unsigned LAUNCH_CYCLES = 4100,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned ADDR_W        = 16,
   parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
   input  logic              clk_osc_i,
   input  logic              rst_pin_i,
   input  logic              kick_i,
   input  logic              flag_clr_i,
   input  logic              wake_i,
   input  logic              dbg_off_i,
   input  logic              emu_en_i,
   output logic              sys_rst_o,
   output logic              cpu_run_o,
   output logic [ADDR_W-1:0] start_addr_o,
   output logic              ovf_flag_o
);

   if (ADDR_W < 1) begin : g_bad_addr
      $error("hwdog_core: ADDR_W must be at least 1");
   end

   logic [IN_COUNT-1:0] raw_in;
   logic [IN_COUNT-1:0] syn_in;
   logic [1:0]          rises;
   wd_ctrl_t            ctrl;
   logic                hold;
   logic                ovf;
   logic                cnt_clear;

   assign raw_in[IN_KICK] = kick_i;
   assign raw_in[IN_CLR]  = flag_clr_i;
   assign raw_in[IN_WAKE] = wake_i;
   assign raw_in[IN_DBG]  = dbg_off_i;
   assign raw_in[IN_EMU]  = emu_en_i;

   hwdog_sync #(
      .WIDTH  (IN_COUNT),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk_i   (clk_osc_i),
      .rst_i   (rst_pin_i),
      .async_i (raw_in),
      .sync_o  (syn_in)
   );

   hwdog_edge #(
      .WIDTH (2)
   ) edge_i (
      .clk_i   (clk_osc_i),
      .rst_i   (rst_pin_i),
      .level_i ({syn_in[IN_CLR], syn_in[IN_KICK]}),
      .rise_o  (rises)
   );

   assign ctrl.kick_evt = rises[0] & ~hold;
   assign ctrl.clr_evt  = rises[1];
   assign ctrl.awake    = syn_in[IN_WAKE];
   assign ctrl.disabled = syn_in[IN_DBG] | syn_in[IN_EMU];

   assign cnt_clear = ctrl.kick_evt | ~ctrl.awake | ctrl.disabled | hold;

   hwdog_interval #(
      .TERM_COUNT (TERM_COUNT)
   ) interval_i (
      .clk_i   (clk_osc_i),
      .rst_i   (rst_pin_i),
      .clear_i (cnt_clear),
      .ovf_o   (ovf)
   );

   hwdog_launch #(
      .LAUNCH_CYCLES (LAUNCH_CYCLES)
   ) launch_i (
      .clk_i     (clk_osc_i),
      .rst_i     (rst_pin_i),
      .ovf_i     (ovf),
      .clr_evt_i (ctrl.clr_evt),
      .hold_o    (hold),
      .run_o     (cpu_run_o),
      .flag_o    (ovf_flag_o)
   );

   assign sys_rst_o    = hold;
   assign start_addr_o = START_ADDR;

endmodule

// File: rtl/hwdog_chk.sv
module hwdog_chk #(
   parameter int unsigned LAUNCH_CYCLES = 4100,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input logic clk_osc_i,
   input logic rst_pin_i,
   input logic emu_en_i,
   input logic sys_rst_o,
   input logic cpu_run_o,
   input logic ovf_flag_o
);

   localparam int unsigned RUN_W = $clog2(LAUNCH_CYCLES + 2);
   localparam int unsigned EMU_W = $clog2(SYNC_STAGES + 4);
   localparam logic [EMU_W-1:0] EMU_SAT = EMU_W'(SYNC_STAGES + 2);

   logic [RUN_W-1:0] hi_run;
   logic [EMU_W-1:0] emu_run;

   always_ff @(posedge clk_osc_i or posedge rst_pin_i) begin
      if (rst_pin_i) begin
         hi_run  <= '0;
         emu_run <= '0;
      end else begin
         hi_run  <= sys_rst_o ? hi_run + 1'b1 : '0;
         if (!emu_en_i) begin
            emu_run <= '0;
         end else if (emu_run != EMU_SAT) begin
            emu_run <= emu_run + 1'b1;
         end
      end
   end

   // R4: the reset window never outlasts the launch length
   p_hold_max_r4: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      sys_rst_o |-> (hi_run < RUN_W'(LAUNCH_CYCLES)));

   // R4: the reset window ends exactly at the launch length
   p_hold_len_r4: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      $fell(sys_rst_o) |-> ($past(hi_run) == RUN_W'(LAUNCH_CYCLES - 1)));

   // R4: the processor is released as the window closes
   p_release_r4: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      $fell(sys_rst_o) |-> cpu_run_o);

   // R4: reset request and processor run are never both active
   p_excl_r4: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      !(sys_rst_o && cpu_run_o));

   // R5: an overflow always leaves the flag set
   p_flag_set_r5: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      $rose(sys_rst_o) |-> ovf_flag_o);

   // R5: the flag never rises without an overflow
   p_flag_src_r5: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      $rose(ovf_flag_o) |-> $rose(sys_rst_o));

   // R9: no overflow once the emulator input has settled high
   p_emu_off_r9: assert property (@(posedge clk_osc_i) disable iff (rst_pin_i)
      $rose(sys_rst_o) |-> (emu_run <= EMU_W'(SYNC_STAGES + 1)));

endmodule

bind hwdog_core hwdog_chk #(
   .LAUNCH_CYCLES (LAUNCH_CYCLES),
   .SYNC_STAGES   (SYNC_STAGES)
) chk_i (
   .clk_osc_i  (clk_osc_i),
   .rst_pin_i  (rst_pin_i),
   .emu_en_i   (emu_en_i),
   .sys_rst_o  (sys_rst_o),
   .cpu_run_o  (cpu_run_o),
   .ovf_flag_o (ovf_flag_o)
);

// File: tb/hwdog_core_tb_top.sv
`timescale 1ns/1ps
module hwdog_core_tb_top;

   localparam int TERM   = 20;
   localparam int LAUNCH = 7;
   localparam int SYNC   = 2;
   localparam int AW     = 16;

   logic          clk = 1'b0;
   logic          rst_pin = 1'b1;
   logic          kick = 1'b0;
   logic          fclr = 1'b0;
   logic          wake = 1'b1;
   logic          dbg = 1'b0;
   logic          emu = 1'b0;
   logic          sys_rst;
   logic          cpu_run;
   logic [AW-1:0] saddr;
   logic          flag;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   hwdog_core #(
      .TERM_COUNT    (TERM),
      .LAUNCH_CYCLES (LAUNCH),
      .SYNC_STAGES   (SYNC),
      .ADDR_W        (AW),
      .START_ADDR    ('0)
   ) dut_i (
      .clk_osc_i    (clk),
      .rst_pin_i    (rst_pin),
      .kick_i       (kick),
      .flag_clr_i   (fclr),
      .wake_i       (wake),
      .dbg_off_i    (dbg),
      .emu_en_i     (emu),
      .sys_rst_o    (sys_rst),
      .cpu_run_o    (cpu_run),
      .start_addr_o (saddr),
      .ovf_flag_o   (flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_pin = 1'b1; kick = 1'b0; fclr = 1'b0; wake = 1'b1; dbg = 1'b0; emu = 1'b0;
      repeat (2) @(negedge clk);
      rst_pin = 1'b0;
   endtask

   // negedges until sys_rst is seen high; the first negedge counts as 1
   task automatic wait_rise(output int c);
      c = 0;
      do begin
         @(negedge clk);
         c++;
         kick = 1'b0;
      end while (!sys_rst && c < 1000);
   endtask

   // count samples with sys_rst high; optionally kick in the second one
   task automatic hold_len(input bit kick_in_hold, output int h);
      h = 0;
      while (sys_rst && h < 1000) begin
         h++;
         kick = (kick_in_hold && h == 2);
         @(negedge clk);
      end
      kick = 1'b0;
   endtask

   task automatic idle_watch(input int n, output int hits);
      hits = 0;
      repeat (n) begin
         @(negedge clk);
         if (sys_rst) hits++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int c, h, hits;

      // R1: state in reset and right after release
      @(negedge clk);
      chk("R1 sys_rst in reset", int'(sys_rst), 0);
      chk("R1 flag in reset", int'(flag), 0);
      do_reset();
      chk("R1 sys_rst", int'(sys_rst), 0);
      chk("R1 cpu_run", int'(cpu_run), 1);
      chk("R1 flag", int'(flag), 0);
      chk("R1 start_addr", int'(saddr), 0);

      // R2/R11: single refresh then let it run out
      repeat (3) @(negedge clk);
      kick = 1'b1;
      wait_rise(c);
      chk("R11 kick to overflow latency", c, SYNC + TERM + 1);
      chk("R5 flag at overflow", int'(flag), 1);
      chk("R4 cpu_run held", int'(cpu_run), 0);
      // R4/R10: hold length with a refresh injected inside the window
      hold_len(1'b1, h);
      chk("R10 R4 hold length with kick", h, LAUNCH);
      chk("R4 cpu_run released", int'(cpu_run), 1);
      chk("R4 start address", int'(saddr), 0);
      chk("R5 flag survives hold", int'(flag), 1);
      wait_rise(c);
      chk("R10 R2 release to next overflow", c, TERM);
      hold_len(1'b0, h);
      chk("R4 second hold length", h, LAUNCH);

      // R6: firmware clear
      fclr = 1'b1;
      @(negedge clk);
      fclr = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 flag after clear strobe", int'(flag), 0);
      wait_rise(c);
      chk("R5 flag set again", int'(flag), 1);

      // R7: reset pin clears flag asynchronously
      #1 rst_pin = 1'b1;
      #0.5;
      chk("R7 flag on reset pin", int'(flag), 0);
      chk("R7 sys_rst on reset pin", int'(sys_rst), 0);
      chk("R7 cpu_run on reset pin", int'(cpu_run), 1);

      // R3: sweep of refresh spacing
      for (int p = 2; p <= TERM + 1; p++) begin
         do_reset();
         repeat (3) @(negedge clk);
         for (int i = 0; i < 5; i++) begin
            kick = 1'b1;
            @(negedge clk);
            kick = 1'b0;
            repeat (p - 1) @(negedge clk);
         end
         chk($sformatf("R3 spacing %0d flag", p), int'(flag), (p > TERM) ? 1 : 0);
      end

      // R8: wake low holds the counter
      do_reset();
      wake = 1'b0;
      idle_watch(3 * TERM, hits);
      chk("R8 no overflow while asleep", hits, 0);
      chk("R8 flag while asleep", int'(flag), 0);
      wake = 1'b1;
      wait_rise(c);
      chk("R8 R11 wake release to overflow", c, SYNC + TERM);

      // R9: debug disable
      do_reset();
      dbg = 1'b1;
      idle_watch(3 * TERM, hits);
      chk("R9 no overflow debug-off", hits, 0);
      dbg = 1'b0;
      wait_rise(c);
      chk("R9 R11 debug release to overflow", c, SYNC + TERM);

      // R9: emulator enable
      do_reset();
      emu = 1'b1;
      idle_watch(3 * TERM, hits);
      chk("R9 no overflow emulator", hits, 0);
      chk("R9 flag emulator", int'(flag), 0);
      emu = 1'b0;
      wait_rise(c);
      chk("R9 R11 emulator release to overflow", c, SYNC + TERM);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule